// File: doc/BRIEF.md
# Address-Decoder Fault Injection RAM

This block is a small register-file RAM whose address decoder can be made faulty on purpose. A march-test engine under development drives it exactly like an ordinary synchronous RAM (address, write enable, read enable, write data, read data), while a static fault table decides which storage cells each access actually reaches. With an empty table the block is a plain one-to-one RAM. Each table entry carries a fault kind and two address fields. The kinds cover these cases:

- an address that reaches no cell
- a cell that no address reaches
- an address that reaches two cells
- an address diverted onto another address's cell
- a history-dependent stuck-open decoder line

The decoder behaves identically for reads and writes. A write through a multi-cell selection updates every selected cell. A read over several cells returns their common value when they agree. When they disagree, a run-time merge mode picks bitwise AND, bitwise OR or a pseudo-random word. A read that selects nothing returns the fixed floating value `FLOAT_VALUE`, which defaults to all ones.

Read data is registered and appears one clock after the read request. It then holds until the next read. If write and read are requested together, the read returns the contents from before the write. Reset is asynchronous and active-low, and is released through a two-stage synchronizer.

Top module: `addr_fault_ram`

## Requirements
- R1: After reset, `rd_data` is zero.
- R2: With every entry kind set to 0 (none), a write to address A followed by a read of A returns the written data on `rd_data` in the cycle after the read request.
- R3: Entry kind 1 (dead address) on address a: writes to a change no cell, and a read of a returns `FLOAT_VALUE` (all ones by default).
- R4: Entry kind 2 (orphan cell) on address a: cell a is removed from every selection. Reads of a return `FLOAT_VALUE`, its old content can never be read back, and other addresses behave normally.
- R5: Entry kind 3 (double select) with fields a and b: a write to a updates cells a and b together, so a later read of b returns that data.
- R6: Entry kind 4 (alias) with fields a and b: address a reaches only cell b. A write to a is read back at b, and cell a keeps its old content.
- R7: A read over several cells that all hold the same value returns that value, whatever the merge mode.
- R8: A read over cells that differ returns their bitwise AND when `merge_mode` is 2'b00, and their bitwise OR when it is 2'b01. Both 2'b10 and 2'b11 select a pseudo-random word.
- R9: Entry kind 5 (stuck-open) with fields a and b: an access to a that comes right after an access to b reaches cell b. After any other access, or as the first access after reset, it reaches cell a.
- R10: Entries are searched from index 0 upward, and the first entry whose field a equals the address decides its mapping. Kind-2 masks apply on top of that mapping.
- R11: `rd_data` keeps its value in cycles without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| addr | input | ADDR_W | Access address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| merge_mode | input | 2 | Read merge for differing cells: 00 AND, 01 OR, 1x pseudo-random |
| cfg_kind | input | N_ENT*3 | Fault kind per entry, entry i at bits [3i+2:3i] |
| cfg_addr_a | input | N_ENT*ADDR_W | Field a per entry (matched address or affected cell) |
| cfg_addr_b | input | N_ENT*ADDR_W | Field b per entry (second cell or partner address) |

## Verification
A wrong selection vector in the decoder stays hidden until the affected cell is read back. It then shows on `rd_data` one clock after that read as the wrong word, the floating value, or a merged value. A corrupted stuck-open history register shows only when the defective address directly follows its partner address, so the bench pairs those accesses back to back on purpose. A stray write enable on an unselected cell shows on `rd_data` at the first later read of that cell. A merge-logic fault shows in the cycle after a read over cells that disagree.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [2:0] {
    FK_NONE     = 3'd0,
    FK_DEAD     = 3'd1,
    FK_ORPHAN   = 3'd2,
    FK_DOUBLE   = 3'd3,
    FK_ALIAS    = 3'd4,
    FK_STUCKOPN = 3'd5
  } fault_kind_t;

  typedef enum logic [1:0] {
    MG_AND  = 2'b00,
    MG_OR   = 2'b01,
    MG_RND0 = 2'b10,
    MG_RND1 = 2'b11
  } merge_t;

  localparam int KIND_W = 3;
endpackage

// File: rtl/fde_decoder.sv
module fde_decoder
  import fde_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_ENT  = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_ENT*KIND_W-1:0]   cfg_kind,
  input  logic [N_ENT*ADDR_W-1:0]   cfg_addr_a,
  input  logic [N_ENT*ADDR_W-1:0]   cfg_addr_b,
  output logic [DEPTH-1:0]          sel
);
  logic [ADDR_W-1:0] prev_q, prev_d;
  logic              prev_v_q, prev_v_d;
  logic [DEPTH-1:0]  mapped, mask;
  logic              hit;
  logic              tbl_empty;

  always_comb begin
    mapped    = '0;
    mapped[addr] = 1'b1;
    mask      = '0;
    hit       = 1'b0;
    tbl_empty = 1'b1;
    for (int i = 0; i < N_ENT; i++) begin
      fault_kind_t       k;
      logic [ADDR_W-1:0] fa, fb;
      k  = fault_kind_t'(cfg_kind[i*KIND_W +: KIND_W]);
      fa = cfg_addr_a[i*ADDR_W +: ADDR_W];
      fb = cfg_addr_b[i*ADDR_W +: ADDR_W];
      if (k != FK_NONE) tbl_empty = 1'b0;
      if (k == FK_ORPHAN) mask[fa] = 1'b1;
      if (!hit && (k == FK_DEAD || k == FK_DOUBLE || k == FK_ALIAS || k == FK_STUCKOPN)
          && fa == addr) begin
        hit    = 1'b1;
        mapped = '0;
        case (k)
          FK_DEAD:   mapped = '0;
          FK_DOUBLE: begin mapped[fa] = 1'b1; mapped[fb] = 1'b1; end
          FK_ALIAS:  mapped[fb] = 1'b1;
          default: begin
            if (prev_v_q && prev_q == fb) mapped[fb] = 1'b1;
            else                          mapped[fa] = 1'b1;
          end
        endcase
      end
    end
    sel = mapped & ~mask;
  end

  always_comb begin
    prev_d   = prev_q;
    prev_v_d = prev_v_q;
    if (acc) begin
      prev_d   = addr;
      prev_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_v_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      prev_v_q <= prev_v_d;
    end
  end

  p_onehot_when_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_empty |-> $onehot(sel));
  p_at_most_two_cells_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) <= 2);
endmodule

// File: rtl/fde_cell_array.sv
module fde_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [DEPTH-1:0]        sel,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DEPTH*DATA_W-1:0] cells
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] mem_q;
    logic              wr_en;
    assign wr_en = we & sel[g];
    always_ff @(posedge clk) begin
      if (wr_en) mem_q <= wr_data;
    end
    assign cells[g*DATA_W +: DATA_W] = mem_q;

    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel[g]) |=> cells[g*DATA_W +: DATA_W] == $past(wr_data));
    p_unselected_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel[g]) |=> $stable(cells[g*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/fde_read_merge.sv
module fde_read_merge
  import fde_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter logic [DATA_W-1:0] FLOAT_VALUE = '1,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LFSR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    re,
  input  logic [1:0]              merge_mode,
  input  logic [DEPTH-1:0]        sel,
  input  logic [DEPTH*DATA_W-1:0] cells,
  output logic [DATA_W-1:0]       rd_data
);
  logic [DATA_W-1:0] and_v, or_v, merged, rd_d, rd_q;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [LFSR_W*((DATA_W+LFSR_W-1)/LFSR_W)-1:0] rnd_ext;

  assign rnd_ext = {((DATA_W+LFSR_W-1)/LFSR_W){lfsr_q}};

  always_comb begin
    and_v = '1;
    or_v  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        and_v = and_v & cells[i*DATA_W +: DATA_W];
        or_v  = or_v  | cells[i*DATA_W +: DATA_W];
      end
    end
    if (sel == '0)        merged = FLOAT_VALUE;
    else if (and_v == or_v) merged = and_v;
    else begin
      case (merge_t'(merge_mode))
        MG_AND:  merged = and_v;
        MG_OR:   merged = or_v;
        default: merged = rnd_ext[DATA_W-1:0];
      endcase
    end
  end

  always_comb begin
    rd_d   = rd_q;
    lfsr_d = lfsr_q;
    if (re) begin
      rd_d   = merged;
      lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      lfsr_q <= 16'hACE1;
    end else begin
      rd_q   <= rd_d;
      lfsr_q <= lfsr_d;
    end
  end

  assign rd_data = rd_q;

  p_float_on_empty_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (re && sel == '0) |=> rd_data == FLOAT_VALUE);
  p_hold_without_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rd_data));
  p_lfsr_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/addr_fault_ram.sv
module addr_fault_ram
  import fde_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int N_ENT  = 4,
  parameter logic [DATA_W-1:0] FLOAT_VALUE = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [1:0]                merge_mode,
  input  logic [N_ENT*3-1:0]        cfg_kind,
  input  logic [N_ENT*ADDR_W-1:0]   cfg_addr_a,
  input  logic [N_ENT*ADDR_W-1:0]   cfg_addr_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic [DEPTH-1:0]        sel;
  logic [DEPTH*DATA_W-1:0] cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fde_decoder #(.ADDR_W(ADDR_W), .N_ENT(N_ENT)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .acc(we | re), .addr(addr),
    .cfg_kind(cfg_kind), .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
    .sel(sel)
  );

  fde_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_int_n), .we(we), .sel(sel),
    .wr_data(wr_data), .cells(cells)
  );

  fde_read_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLOAT_VALUE(FLOAT_VALUE)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .re(re), .merge_mode(merge_mode),
    .sel(sel), .cells(cells), .rd_data(rd_data)
  );

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_int_n |=> (rd_data == '0) || !rst_int_n);
endmodule

// File: tb/addr_fault_ram_tb.sv
module addr_fault_ram_tb_top;
  localparam int AW = 4, DW = 4, NE = 4, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [1:0] merge_mode = 2'b00;
  logic [NE*3-1:0] cfg_kind = '0;
  logic [NE*AW-1:0] cfg_addr_a = '0, cfg_addr_b = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [AW-1:0] m_prev = '0;
  logic m_prev_v = 1'b0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  addr_fault_ram #(.ADDR_W(AW), .DATA_W(DW), .N_ENT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .merge_mode(merge_mode), .cfg_kind(cfg_kind),
    .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ent(int i, int k, int a, int b);
    cfg_kind[i*3 +: 3]     = 3'(k);
    cfg_addr_a[i*AW +: AW] = AW'(a);
    cfg_addr_b[i*AW +: AW] = AW'(b);
  endtask

  function automatic logic [DEPTH-1:0] exp_sel(logic [AW-1:0] ad);
    logic [DEPTH-1:0] s = '0, m = '0;
    logic found = 1'b0;
    s[ad] = 1'b1;
    for (int i = 0; i < NE; i++) begin
      int k = int'(cfg_kind[i*3 +: 3]);
      logic [AW-1:0] fa = cfg_addr_a[i*AW +: AW], fb = cfg_addr_b[i*AW +: AW];
      if (k == 2) m[fa] = 1'b1;
      if (!found && k >= 1 && k <= 5 && k != 2 && fa == ad) begin
        found = 1'b1;
        s = '0;
        if (k == 3) begin s[fa] = 1'b1; s[fb] = 1'b1; end
        else if (k == 4) s[fb] = 1'b1;
        else if (k == 5) begin
          if (m_prev_v && m_prev == fb) s[fb] = 1'b1; else s[fa] = 1'b1;
        end
      end
    end
    return s & ~m;
  endfunction

  // returns 1 in bit DW when the value is not predictable (random merge)
  function automatic logic [DW:0] exp_read(logic [DEPTH-1:0] s);
    logic [DW-1:0] av = '1, ov = '0;
    if (s == '0) return {1'b0, {DW{1'b1}}};
    for (int i = 0; i < DEPTH; i++)
      if (s[i]) begin av &= mdl[i]; ov |= mdl[i]; end
    if (av == ov) return {1'b0, av};
    if (merge_mode == 2'b00) return {1'b0, av};
    if (merge_mode == 2'b01) return {1'b0, ov};
    return {1'b1, av};
  endfunction

  task automatic wr(int a, logic [DW-1:0] d);
    logic [DEPTH-1:0] s;
    @(negedge clk);
    s = exp_sel(AW'(a));
    we = 1'b1; addr = AW'(a); wr_data = d;
    @(posedge clk); #2;
    we = 1'b0;
    for (int i = 0; i < DEPTH; i++) if (s[i]) mdl[i] = d;
    m_prev = AW'(a); m_prev_v = 1'b1;
  endtask

  task automatic rd(int a, string req);
    logic [DW:0] e;
    @(negedge clk);
    e = exp_read(exp_sel(AW'(a)));
    re = 1'b1; addr = AW'(a);
    @(posedge clk); #2;
    re = 1'b0;
    if (!e[DW]) chk(req, rd_data, e[DW-1:0]);
    last_rd = rd_data;
    m_prev = AW'(a); m_prev_v = 1'b1;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, '0);

    // R2: clean table, fill every cell
    for (int i = 0; i < DEPTH; i++) wr(i, DW'(i * 5 + 3));
    for (int i = 0; i < DEPTH; i++) rd(i, "R2 one-to-one");
    // R11: hold
    repeat (3) @(negedge clk);
    chk("R11 hold without read", rd_data, last_rd);

    // R3 dead address 3, R4 orphan cell 5, R5 double 7->9, R6 alias 10->12
    set_ent(0, 1, 3, 0);
    set_ent(1, 2, 5, 0);
    set_ent(2, 3, 7, 9);
    set_ent(3, 4, 10, 12);
    wr(3, 4'h6);
    rd(3, "R3 dead address reads float");
    set_ent(0, 0, 0, 0); rd(3, "R3 dead write left cell");
    set_ent(0, 1, 3, 0);
    rd(5, "R4 orphan reads float");
    wr(5, 4'h2); rd(6, "R4 neighbour intact");
    wr(7, 4'hA); rd(9, "R5 double write reaches b");
    rd(7, "R7 equal cells read");
    wr(10, 4'h4); rd(12, "R6 alias lands on b");
    set_ent(3, 0, 0, 0); rd(10, "R6 alias cell a kept");
    rd(5, "R4 orphan old content hidden");
    // R8 differing cells under double select 7/9
    set_ent(2, 0, 0, 0); wr(9, 4'h5); wr(7, 4'h3); set_ent(2, 3, 7, 9);
    merge_mode = 2'b00; rd(7, "R8 AND merge");
    chk("R8 AND value", rd_data, 4'h1);
    merge_mode = 2'b01; rd(7, "R8 OR merge");
    chk("R8 OR value", rd_data, 4'h7);
    merge_mode = 2'b10; wr(9, 4'h3); rd(7, "R7 equal under random mode");
    // R10 priority: alias 7->1 at entry 0 before double at entry 2
    set_ent(0, 4, 7, 1);
    wr(7, 4'hE); rd(1, "R10 first entry wins");
    rd(9, "R10 later entry ignored");
    chk("R10 cell 9 untouched", rd_data, 4'h3);

    // R9 stuck-open, defective 14, partner 15
    set_ent(0, 5, 14, 15); set_ent(1, 0, 0, 0); set_ent(2, 0, 0, 0); set_ent(3, 0, 0, 0);
    merge_mode = 2'b00;
    wr(14, 4'h1); wr(2, 4'h0); rd(14, "R9 normal after other");
    chk("R9 value", rd_data, 4'h1);
    wr(15, 4'h0); rd(14, "R9 reaches partner after partner");
    chk("R9 partner value", rd_data, 4'h0);
    wr(15, 4'h9); wr(14, 4'hC); rd(15, "R9 write via stuck line");
    chk("R9 write value", rd_data, 4'hC);

    // random mix with a fixed fault table
    set_ent(0, 5, 13, 11);
    set_ent(1, 3, 4, 8);
    set_ent(2, 2, 6, 0);
    set_ent(3, 1, 0, 0);
    for (int n = 0; n < 400; n++) begin
      int a = int'($urandom_range(0, DEPTH - 1));
      if (n % 50 == 0) merge_mode = 2'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) wr(a, DW'($urandom));
      else rd(a, "R10 random mixed table");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule